// File: doc/BRIEF.md
# Soft Interrupt Pending Register with Tick Compare

This block keeps one processor's interrupt-pending vector of 17 bits. Software raises pending bits through a set port that ORs a mask in and lowers them through a clear port that removes a mask. Bits 15 to 1 stand for software interrupt levels 1 to 15. Bit 0 is raised by the tick timer and bit 16 by the system-tick timer. The full vector is always visible on a read port.

Each timer is a free-running counter that steps by one on every cycle its enable is high, and software can load it. Each timer has a compare register. Its low bits hold the match value and its top bit turns the interrupt off. When a counter arrives at the value of an enabled compare register, the timer's pending bit is raised and stays raised until software clears it. The block also reports the highest pending level at all times. Both timer bits count as level 14.

Top module: `softint_tick_ctrl`

## Requirements
- R1: After reset the pending vector is 0, both counters are 0, both compare registers read with bit 63 = 1 and low bits 0, and the level output is 0.
- R2: A set write ORs set_mask_i into the pending vector, and the result is visible after the next clock edge.
- R3: A clear write removes the bits of clr_mask_i from the pending vector on the next clock edge.
- R4: When the set and clear ports hit the same bit in the same cycle, that bit ends up set.
- R5: With no write and no timer match, the pending vector holds its value.
- R6: A counter increases by exactly one on each edge where its enable is high, and holds its value when the enable is low.
- R7: A counter load replaces the counter value on the next edge. A load takes precedence over the increment.
- R8: When a counter becomes equal to bits 62:0 of its compare register and bit 63 of that register is 0, the timer's pending bit is set on the following edge. The tick timer sets bit 0 and the system-tick timer sets bit 16. The bit stays set until it is cleared, and it is raised only once for each arrival at the match value.
- R9: While bit 63 of a compare register is 1, a match never sets that timer's pending bit.
- R10: level_o is the highest number n from 1 to 15 for which bit n is pending, or 0 when no level is pending.
- R11: Pending bit 0 and pending bit 16 each count as level 14 when level_o is formed.
- R12: A timer match and a clear of the same bit in the same cycle leave the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| set_we_i | input | 1 | Set-port write strobe |
| set_mask_i | input | 17 | Bits to set in the pending vector |
| clr_we_i | input | 1 | Clear-port write strobe |
| clr_mask_i | input | 17 | Bits to clear in the pending vector |
| pend_o | output | 17 | Pending vector read port |
| level_o | output | 4 | Highest pending level, 0 when none |
| tick_en_i | input | 1 | Tick counter count enable |
| tick_ld_i | input | 1 | Tick counter load strobe |
| tick_ld_val_i | input | 63 | Tick counter load value |
| tick_cmp_we_i | input | 1 | Tick compare register write strobe |
| tick_cmp_wdata_i | input | 64 | Tick compare write data, bit 63 is the disable bit |
| tick_cnt_o | output | 63 | Tick counter value |
| tick_cmp_o | output | 64 | Tick compare register value |
| stick_en_i | input | 1 | System-tick counter count enable |
| stick_ld_i | input | 1 | System-tick counter load strobe |
| stick_ld_val_i | input | 63 | System-tick counter load value |
| stick_cmp_we_i | input | 1 | System-tick compare register write strobe |
| stick_cmp_wdata_i | input | 64 | System-tick compare write data, bit 63 is the disable bit |
| stick_cnt_o | output | 63 | System-tick counter value |
| stick_cmp_o | output | 64 | System-tick compare register value |

## Verification
The hardest case to reach from the ports is a timer match that lands in the same cycle as a software clear of the same bit. A 63-bit counter cannot be run to a chosen value, so the stimulus first loads the counter a few counts below the compare value. It then enables counting and watches the counter output at each falling edge. When the counter shows the match value, the bench drives the clear on that same cycle. The same approach places the counter exactly on the match value, so the bench can show that the pending bit is still 0 in that cycle and is 1 one cycle later. The pending-vector encoder is then swept over all single bits and a few hundred computed patterns.

// File: rtl/softint_pkg.sv
package softint_pkg;
  localparam int NUM_SRC   = 2;
  localparam int PEND_W    = 17;
  localparam int LVL_W     = 4;
  localparam int NUM_LVL   = 15;
  localparam int TICK_BIT  = 0;
  localparam int STICK_BIT = 16;
  localparam int TIMER_LVL = 14;
endpackage

// File: rtl/softint_timer.sv
module softint_timer #(
  parameter int CNT_W = 63,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             cmp_we_i,
  input  logic [CMP_W-1:0] cmp_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CMP_W-1:0] cmp_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CMP_W-1:0] cmp_q;
  logic             eq, eq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (en_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  // reset value keeps the compare disabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= {1'b1, {CNT_W{1'b0}}};
    else if (cmp_we_i) cmp_q <= cmp_wdata_i;
  end

  assign eq = !cmp_q[CNT_W] && (cnt_q == cmp_q[CNT_W-1:0]);

  // one hit per arrival at the match value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eq_q <= 1'b0;
    else         eq_q <= eq;
  end

  assign hit_o = eq && !eq_q;
  assign cnt_o = cnt_q;
  assign cmp_o = cmp_q;

  p_inc_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && en_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_i && !en_i) |=> $stable(cnt_q));
  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_q == $past(ld_val_i)));
endmodule

// File: rtl/softint_pend.sv
module softint_pend
  import softint_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic [PEND_W-1:0] set_mask_i,
  input  logic              clr_we_i,
  input  logic [PEND_W-1:0] clr_mask_i,
  input  logic [PEND_W-1:0] hw_set_i,
  output logic [PEND_W-1:0] pend_o
);
  logic [PEND_W-1:0] pend_q, set_v, clr_v;

  assign set_v = (set_we_i ? set_mask_i : '0) | hw_set_i;
  assign clr_v = clr_we_i ? clr_mask_i : '0;

  // set after clear: set wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_v) | set_v;
  end

  assign pend_o = pend_q;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_we_i |=> ((pend_q & $past(set_mask_i)) == $past(set_mask_i)));
  p_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((pend_q & $past(clr_mask_i & ~set_v)) == '0));
  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && clr_we_i) |=>
      ((pend_q & $past(set_mask_i & clr_mask_i)) == $past(set_mask_i & clr_mask_i)));
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i && hw_set_i == '0) |=> $stable(pend_q));
  p_hw_beats_clr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_set_i != '0) |=> ((pend_q & $past(hw_set_i)) == $past(hw_set_i)));
endmodule

// File: rtl/softint_level.sv
module softint_level
  import softint_pkg::*;
(
  input  logic [PEND_W-1:0] pend_i,
  output logic [LVL_W-1:0]  level_o
);
  logic [NUM_LVL:1] eff;

  always_comb begin
    eff = pend_i[NUM_LVL:1];
    eff[TIMER_LVL] = eff[TIMER_LVL] | pend_i[TICK_BIT] | pend_i[STICK_BIT];
  end

  always_comb begin
    level_o = '0;
    for (int i = 1; i <= NUM_LVL; i++)
      if (eff[i]) level_o = LVL_W'(i);
  end
endmodule

// File: rtl/softint_tick_ctrl.sv
module softint_tick_ctrl
  import softint_pkg::*;
#(
  parameter int CNT_W = 63,
  localparam int CMP_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic [PEND_W-1:0] set_mask_i,
  input  logic              clr_we_i,
  input  logic [PEND_W-1:0] clr_mask_i,
  output logic [PEND_W-1:0] pend_o,
  output logic [LVL_W-1:0]  level_o,
  input  logic              tick_en_i,
  input  logic              tick_ld_i,
  input  logic [CNT_W-1:0]  tick_ld_val_i,
  input  logic              tick_cmp_we_i,
  input  logic [CMP_W-1:0]  tick_cmp_wdata_i,
  output logic [CNT_W-1:0]  tick_cnt_o,
  output logic [CMP_W-1:0]  tick_cmp_o,
  input  logic              stick_en_i,
  input  logic              stick_ld_i,
  input  logic [CNT_W-1:0]  stick_ld_val_i,
  input  logic              stick_cmp_we_i,
  input  logic [CMP_W-1:0]  stick_cmp_wdata_i,
  output logic [CNT_W-1:0]  stick_cnt_o,
  output logic [CMP_W-1:0]  stick_cmp_o
);
  localparam int SRC_BIT [NUM_SRC] = '{TICK_BIT, STICK_BIT};

  logic             en     [NUM_SRC];
  logic             ld     [NUM_SRC];
  logic [CNT_W-1:0] ld_val [NUM_SRC];
  logic             cmp_we [NUM_SRC];
  logic [CMP_W-1:0] cmp_wd [NUM_SRC];
  logic [CNT_W-1:0] cnt    [NUM_SRC];
  logic [CMP_W-1:0] cmp    [NUM_SRC];
  logic             hit    [NUM_SRC];
  logic [PEND_W-1:0] hw_set;

  assign en[0] = tick_en_i;         assign en[1] = stick_en_i;
  assign ld[0] = tick_ld_i;         assign ld[1] = stick_ld_i;
  assign ld_val[0] = tick_ld_val_i; assign ld_val[1] = stick_ld_val_i;
  assign cmp_we[0] = tick_cmp_we_i; assign cmp_we[1] = stick_cmp_we_i;
  assign cmp_wd[0] = tick_cmp_wdata_i;
  assign cmp_wd[1] = stick_cmp_wdata_i;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_timer
    softint_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (en[s]),
      .ld_i        (ld[s]),
      .ld_val_i    (ld_val[s]),
      .cmp_we_i    (cmp_we[s]),
      .cmp_wdata_i (cmp_wd[s]),
      .cnt_o       (cnt[s]),
      .cmp_o       (cmp[s]),
      .hit_o       (hit[s])
    );
  end

  always_comb begin
    hw_set = '0;
    for (int s = 0; s < NUM_SRC; s++)
      hw_set[SRC_BIT[s]] = hit[s];
  end

  assign tick_cnt_o  = cnt[0];
  assign tick_cmp_o  = cmp[0];
  assign stick_cnt_o = cnt[1];
  assign stick_cmp_o = cmp[1];

  softint_pend u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_we_i   (set_we_i),
    .set_mask_i (set_mask_i),
    .clr_we_i   (clr_we_i),
    .clr_mask_i (clr_mask_i),
    .hw_set_i   (hw_set),
    .pend_o     (pend_o)
  );

  softint_level u_level (
    .pend_i  (pend_o),
    .level_o (level_o)
  );

  p_dis_tick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_cmp_o[CNT_W] && !set_we_i && !pend_o[TICK_BIT]) |=> !pend_o[TICK_BIT]);
  p_dis_stick_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stick_cmp_o[CNT_W] && !set_we_i && !pend_o[STICK_BIT]) |=> !pend_o[STICK_BIT]);
  p_level_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == '0) == (pend_o == '0));
  p_level_top_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o[NUM_LVL] |-> (level_o == LVL_W'(NUM_LVL)));
  p_timer_lvl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o[TICK_BIT] || pend_o[STICK_BIT]) && !pend_o[NUM_LVL]) |->
      (level_o == LVL_W'(TIMER_LVL)));
endmodule

// File: tb/softint_tick_ctrl_tb.sv
module softint_tick_ctrl_tb;
  localparam int PW = 17;
  localparam int CW = 63;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic set_we = 0, clr_we = 0;
  logic [PW-1:0] set_mask = '0, clr_mask = '0, pend;
  logic [3:0] level;
  logic t_en = 0, t_ld = 0, t_cwe = 0, s_en = 0, s_ld = 0, s_cwe = 0;
  logic [CW-1:0] t_ldv = '0, s_ldv = '0, t_cnt, s_cnt;
  logic [CW:0] t_cwd = '0, s_cwd = '0, t_cmp, s_cmp;

  int n_chk = 0, n_err = 0;

  softint_tick_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .set_we_i(set_we), .set_mask_i(set_mask),
    .clr_we_i(clr_we), .clr_mask_i(clr_mask),
    .pend_o(pend), .level_o(level),
    .tick_en_i(t_en), .tick_ld_i(t_ld), .tick_ld_val_i(t_ldv),
    .tick_cmp_we_i(t_cwe), .tick_cmp_wdata_i(t_cwd),
    .tick_cnt_o(t_cnt), .tick_cmp_o(t_cmp),
    .stick_en_i(s_en), .stick_ld_i(s_ld), .stick_ld_val_i(s_ldv),
    .stick_cmp_we_i(s_cwe), .stick_cmp_wdata_i(s_cwd),
    .stick_cnt_o(s_cnt), .stick_cmp_o(s_cmp)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_level(logic [PW-1:0] m);
    logic [15:1] e;
    logic [3:0] l;
    e = m[15:1];
    if (m[0] || m[16]) e[14] = 1'b1;
    l = 0;
    for (int i = 1; i <= 15; i++) if (e[i]) l = 4'(i);
    return l;
  endfunction

  task automatic wr_set(logic [PW-1:0] m);
    set_we = 1; set_mask = m;
    @(negedge clk);
    set_we = 0;
  endtask

  task automatic wr_clr(logic [PW-1:0] m);
    clr_we = 1; clr_mask = m;
    @(negedge clk);
    clr_we = 0;
  endtask

  task automatic tick_run_to(logic [CW-1:0] v);
    for (int k = 0; k < 40 && t_cnt != v; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [PW-1:0] m, c;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 pend", 64'(pend), 0);
    check("R1 level", 64'(level), 0);
    check("R1 tick cnt", 64'(t_cnt), 0);
    check("R1 stick cnt", 64'(s_cnt), 0);
    check("R1 tick cmp", t_cmp, 64'h8000_0000_0000_0000);
    check("R1 stick cmp", s_cmp, 64'h8000_0000_0000_0000);

    // R2 R10 R11: single bits
    for (int b = 0; b < PW; b++) begin
      wr_clr('1);
      wr_set(PW'(1) << b);
      check("R2 single", 64'(pend), 64'(PW'(1) << b));
      check("R10 R11 single level", 64'(level), 64'(exp_level(PW'(1) << b)));
    end

    // R2 R3 R5 R10 pattern sweep
    for (int i = 0; i < 300; i++) begin
      m = PW'((i * 32'h0001_3A5B) ^ (i << 9) ^ (i >> 2));
      c = PW'((i * 32'h0000_7C1D) ^ 32'h0001_5555);
      wr_clr('1);
      check("R3 clear all", 64'(pend), 0);
      wr_set(m);
      check("R2 set", 64'(pend), 64'(m));
      check("R10 level", 64'(level), 64'(exp_level(m)));
      @(negedge clk);
      check("R5 hold", 64'(pend), 64'(m));
      wr_clr(c);
      check("R3 clear", 64'(pend), 64'(m & ~c));
      check("R10 level after clear", 64'(level), 64'(exp_level(m & ~c)));
      // R4: set and clear same cycle
      set_we = 1; set_mask = c; clr_we = 1; clr_mask = m | c;
      @(negedge clk);
      set_we = 0; clr_we = 0;
      check("R4 set wins", 64'(pend), 64'(c));
    end
    wr_clr('1);

    // R7 load, R6 increment and hold
    t_ld = 1; t_ldv = 63'd100;
    @(negedge clk);
    t_ld = 0;
    check("R7 tick load", 64'(t_cnt), 100);
    for (int k = 1; k <= 4; k++) begin
      t_en = 1;
      @(negedge clk);
      check("R6 tick inc", 64'(t_cnt), 64'(100 + k));
    end
    t_en = 0;
    repeat (3) @(negedge clk);
    check("R6 tick hold", 64'(t_cnt), 104);
    t_en = 1; t_ld = 1; t_ldv = 63'd50;
    @(negedge clk);
    t_ld = 0; t_en = 0;
    check("R7 load beats inc", 64'(t_cnt), 50);
    s_ld = 1; s_ldv = {1'b1, 62'h3};
    @(negedge clk);
    s_ld = 0;
    check("R7 stick load", 64'(s_cnt), 64'({1'b1, 62'h3}));
    s_en = 1;
    @(negedge clk);
    s_en = 0;
    check("R6 stick inc", 64'(s_cnt), 64'({1'b1, 62'h4}));

    // R8 tick match
    t_cwe = 1; t_cwd = {1'b0, 63'd110};
    @(negedge clk);
    t_cwe = 0;
    t_ld = 1; t_ldv = 63'd105;
    @(negedge clk);
    t_ld = 0; t_en = 1;
    tick_run_to(63'd110);
    check("R8 tick at match", 64'(t_cnt), 110);
    check("R8 not yet pending", 64'(pend[0]), 0);
    @(negedge clk);
    check("R8 tick pending", 64'(pend), 1);
    check("R11 tick level", 64'(level), 14);
    repeat (3) @(negedge clk);
    check("R8 sticky", 64'(pend), 1);
    wr_clr(PW'(1));
    repeat (2) @(negedge clk);
    check("R8 once per arrival", 64'(pend), 0);

    // R12 match and clear same cycle
    t_en = 0;
    t_ld = 1; t_ldv = 63'd106;
    @(negedge clk);
    t_ld = 0; t_en = 1;
    tick_run_to(63'd110);
    clr_we = 1; clr_mask = PW'(1);
    @(negedge clk);
    clr_we = 0;
    check("R12 match beats clear", 64'(pend), 1);
    wr_clr('1);

    // R9 disabled compare
    t_en = 0;
    t_cwe = 1; t_cwd = {1'b1, 63'd110};
    @(negedge clk);
    t_cwe = 0;
    t_ld = 1; t_ldv = 63'd105;
    @(negedge clk);
    t_ld = 0; t_en = 1;
    repeat (10) @(negedge clk);
    t_en = 0;
    check("R9 counter passed value", 64'(t_cnt), 115);
    check("R9 tick suppressed", 64'(pend), 0);

    // R8 R11 stick match
    s_cwe = 1; s_cwd = {1'b0, 63'd7};
    @(negedge clk);
    s_cwe = 0;
    s_ld = 1; s_ldv = 63'd3;
    @(negedge clk);
    s_ld = 0; s_en = 1;
    for (int k = 0; k < 40 && s_cnt != 63'd7; k++) @(negedge clk);
    check("R8 stick not yet", 64'(pend[16]), 0);
    @(negedge clk);
    s_en = 0;
    check("R8 stick pending", 64'(pend), 64'(PW'(1) << 16));
    check("R11 stick level", 64'(level), 14);
    wr_set(PW'(1) << 15);
    check("R10 level above timer", 64'(level), 15);
    wr_clr(PW'(1) << 15);
    check("R11 back to 14", 64'(level), 14);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule